// File: doc/BRIEF.md
# Return Stack with Illegal-Condition Trap

This block keeps the subroutine return stack and the program fetch path of a small 8-bit controller. A byte-wide stack pointer addresses a small internal data RAM. A call saves the 16-bit return address as two bytes and jumps. A return restores the address into the program counter. A return-from-interrupt does the same and also turns the global interrupt enable back on.

Program memory lies outside the block. The block drives the fetch address and receives the byte that comes back. Data RAM above its implemented size reads as FF hex and ignores writes. Program memory at 1000 hex and above fetches as 00 hex, the software-interrupt opcode. Any fetched 00 raises a one-cycle trap request. The result is that a return with nothing on the stack loads FFFF into the PC, and the next fetch traps. No separate detector is needed.

Only one of call, pop and step takes effect in a cycle. A call has the highest priority, then a pop (return or return-from-interrupt), then a step. A fetch is independent of these three and always reads the PC value from before the cycle's update.

Top module: `retstack_trap`

## Requirements
- R1: After reset the PC is 0000, the stack pointer is RAM_BYTES-1 (63 by default), the global interrupt enable is 0, the opcode output is 00 and the trap request is 0. In a cycle with no call, pop or step, the PC and the stack pointer hold their values.
- R2: A call stores the return address (PC+1) into the stack and then loads `call_target_i` into the PC. The low byte goes to RAM[sp] and the high byte to RAM[sp-1]. The stack pointer then falls by 2.
- R3: A return loads the PC with high byte RAM[sp+1] and low byte RAM[sp+2], and then raises the stack pointer by 2. RAM addresses wrap modulo 256. Nested calls therefore return in last-in, first-out order.
- R4: A return-from-interrupt pops the stack exactly as R3 does. It also sets the global interrupt enable, unless a call is asserted in the same cycle.
- R5: A data-RAM address at or above RAM_BYTES reads as FF hex, and a write to such an address is discarded. For example, a call made with the stack pointer at 255 is followed by a return to FFFF.
- R6: One cycle after `fetch_i`, `opcode_o` shows the fetched byte. This is `rom_data_i` when the PC is below 1000 hex, and 00 hex otherwise. The opcode holds its value between fetches.
- R7: The cycle after a fetch whose byte is 00 hex, `trap_o` is high for exactly one cycle. This applies whether the 00 came from implemented or undefined memory. At all other times `trap_o` is low.
- R8: A return issued straight after reset loads FFFF into the PC, because it reads undefined RAM. The next fetch then raises a trap.
- R9: A step increments the PC by 1. The priority order is call, then pop, then step.
- R10: A cycle in which `trap_o` is high clears the global interrupt enable at the next edge. A return-from-interrupt in that same cycle wins, and the enable stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call strobe |
| call_target_i | input | 16 | Call destination address |
| ret_i | input | 1 | Return strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| step_i | input | 1 | Advance PC by one |
| fetch_i | input | 1 | Fetch strobe for the byte at the current PC |
| rom_data_i | input | 8 | Byte read from external program memory at `pc_o` |
| pc_o | output | 16 | Program counter and fetch address |
| opcode_o | output | 8 | Last fetched opcode |
| trap_o | output | 1 | Software-interrupt request pulse |
| gie_o | output | 1 | Global interrupt enable |

## Verification
Some rules hold on every cycle, and the assertions check these. They cover the pointer moving by exactly two on each call and each pop, and the PC loading the call target. They also cover steps, idle hold, the enable after a return-from-interrupt and after a trap, and that a trap never appears without a preceding fetch of 00.

Other behaviour can only be shown by bench scenarios. These cover the byte order and content of the stacked addresses, last-in, first-out order over 32 nested calls, and writes to undefined RAM being lost when the pointer wraps. They also cover the unbalanced return from reset reaching FFFF and trapping, and the priority of colliding strobes.

// File: rtl/retstack_pkg.sv
`timescale 1ns/1ps
package retstack_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_CALL,
        OP_POP,
        OP_STEP
    } stk_op_e;

    typedef struct packed {
        addr_t pc;
        byte_t sp;
        logic  gie;
    } seq_state_t;

    typedef struct packed {
        byte_t opcode;
        logic  trap;
    } fetch_state_t;

    localparam byte_t SWI_OPCODE = 8'h00;
    localparam byte_t UNDEF_RAM  = 8'hFF;
endpackage

// File: rtl/retstack_ram.sv
`timescale 1ns/1ps
module retstack_ram
    import retstack_pkg::*;
#(
    parameter int RAM_BYTES = 64
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  byte_t waddr_lo,
    input  byte_t wdata_lo,
    input  byte_t waddr_hi,
    input  byte_t wdata_hi,
    input  byte_t raddr_a,
    output byte_t rdata_a,
    input  byte_t raddr_b,
    output byte_t rdata_b
);
    localparam int         IDX_W  = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;
    localparam logic [8:0] DEPTH9 = 9'(RAM_BYTES);

    byte_t mem_q [RAM_BYTES];

    // one register per implemented location; undefined addresses match no cell
    for (genvar g = 0; g < RAM_BYTES; g++) begin : g_cell
        byte_t cell_d;
        logic  hit_lo;
        logic  hit_hi;

        always_comb begin
            hit_lo = we && (waddr_lo == 8'(g));
            hit_hi = we && (waddr_hi == 8'(g));
            cell_d = mem_q[g];
            if (hit_lo) begin
                cell_d = wdata_lo;
            end else if (hit_hi) begin
                cell_d = wdata_hi;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= cell_d;
            end
        end
    end

    logic a_ok;
    logic b_ok;

    always_comb begin
        a_ok    = {1'b0, raddr_a} < DEPTH9;
        b_ok    = {1'b0, raddr_b} < DEPTH9;
        rdata_a = a_ok ? mem_q[raddr_a[IDX_W-1:0]] : UNDEF_RAM;
        rdata_b = b_ok ? mem_q[raddr_b[IDX_W-1:0]] : UNDEF_RAM;
    end
endmodule

// File: rtl/retstack_fetch.sv
`timescale 1ns/1ps
module retstack_fetch
    import retstack_pkg::*;
#(
    parameter int PROG_BYTES = 4096
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fetch_i,
    input  addr_t pc_i,
    input  byte_t rom_data_i,
    output byte_t opcode_o,
    output logic  trap_o
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(PROG_BYTES);

    fetch_state_t st_d;
    fetch_state_t st_q;
    logic         undefined;
    byte_t        fetched;

    always_comb begin
        undefined   = {1'b0, pc_i} >= LIMIT;
        fetched     = undefined ? SWI_OPCODE : rom_data_i;
        st_d        = st_q;
        st_d.trap   = 1'b0;
        if (fetch_i) begin
            st_d.opcode = fetched;
            st_d.trap   = (fetched == SWI_OPCODE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{opcode: SWI_OPCODE, trap: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign opcode_o = st_q.opcode;
    assign trap_o   = st_q.trap;
endmodule

// File: rtl/retstack_seq.sv
`timescale 1ns/1ps
module retstack_seq
    import retstack_pkg::*;
#(
    parameter int RAM_BYTES = 64
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  call_i,
    input  addr_t call_target_i,
    input  logic  ret_i,
    input  logic  reti_i,
    input  logic  step_i,
    input  logic  trap_i,
    input  byte_t pop_hi_i,
    input  byte_t pop_lo_i,
    output logic  ram_we_o,
    output byte_t waddr_lo_o,
    output byte_t wdata_lo_o,
    output byte_t waddr_hi_o,
    output byte_t wdata_hi_o,
    output byte_t raddr_hi_o,
    output byte_t raddr_lo_o,
    output addr_t pc_o,
    output byte_t sp_o,
    output logic  gie_o
);
    localparam byte_t SP_TOP = 8'(RAM_BYTES - 1);

    seq_state_t st_d;
    seq_state_t st_q;
    stk_op_e    op;
    addr_t      ret_addr;

    always_comb begin
        if (call_i) begin
            op = OP_CALL;
        end else if (ret_i || reti_i) begin
            op = OP_POP;
        end else if (step_i) begin
            op = OP_STEP;
        end else begin
            op = OP_IDLE;
        end
    end

    always_comb begin
        ret_addr   = st_q.pc + 16'd1;
        st_d       = st_q;
        ram_we_o   = 1'b0;
        waddr_lo_o = st_q.sp;
        wdata_lo_o = ret_addr[7:0];
        waddr_hi_o = st_q.sp - 8'd1;
        wdata_hi_o = ret_addr[15:8];
        raddr_hi_o = st_q.sp + 8'd1;
        raddr_lo_o = st_q.sp + 8'd2;

        if (trap_i) begin
            st_d.gie = 1'b0;
        end

        unique case (op)
            OP_CALL: begin
                ram_we_o = 1'b1;
                st_d.sp  = st_q.sp - 8'd2;
                st_d.pc  = call_target_i;
            end
            OP_POP: begin
                st_d.pc = {pop_hi_i, pop_lo_i};
                st_d.sp = st_q.sp + 8'd2;
                if (reti_i) begin
                    st_d.gie = 1'b1;
                end
            end
            OP_STEP: begin
                st_d.pc = st_q.pc + 16'd1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pc: '0, sp: SP_TOP, gie: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o  = st_q.pc;
    assign sp_o  = st_q.sp;
    assign gie_o = st_q.gie;
endmodule

// File: rtl/retstack_trap.sv
`timescale 1ns/1ps
module retstack_trap
    import retstack_pkg::*;
#(
    parameter int PROG_BYTES = 4096,
    parameter int RAM_BYTES  = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        call_i,
    input  logic [15:0] call_target_i,
    input  logic        ret_i,
    input  logic        reti_i,
    input  logic        step_i,
    input  logic        fetch_i,
    input  logic [7:0]  rom_data_i,
    output logic [15:0] pc_o,
    output logic [7:0]  opcode_o,
    output logic        trap_o,
    output logic        gie_o
);
    logic  ram_we;
    byte_t waddr_lo;
    byte_t wdata_lo;
    byte_t waddr_hi;
    byte_t wdata_hi;
    byte_t raddr_hi;
    byte_t raddr_lo;
    byte_t pop_hi;
    byte_t pop_lo;
    byte_t sp_w;
    addr_t pc_w;
    logic  trap_w;

    retstack_seq #(.RAM_BYTES(RAM_BYTES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .call_i       (call_i),
        .call_target_i(call_target_i),
        .ret_i        (ret_i),
        .reti_i       (reti_i),
        .step_i       (step_i),
        .trap_i       (trap_w),
        .pop_hi_i     (pop_hi),
        .pop_lo_i     (pop_lo),
        .ram_we_o     (ram_we),
        .waddr_lo_o   (waddr_lo),
        .wdata_lo_o   (wdata_lo),
        .waddr_hi_o   (waddr_hi),
        .wdata_hi_o   (wdata_hi),
        .raddr_hi_o   (raddr_hi),
        .raddr_lo_o   (raddr_lo),
        .pc_o         (pc_w),
        .sp_o         (sp_w),
        .gie_o        (gie_o)
    );

    retstack_ram #(.RAM_BYTES(RAM_BYTES)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ram_we),
        .waddr_lo(waddr_lo),
        .wdata_lo(wdata_lo),
        .waddr_hi(waddr_hi),
        .wdata_hi(wdata_hi),
        .raddr_a (raddr_hi),
        .rdata_a (pop_hi),
        .raddr_b (raddr_lo),
        .rdata_b (pop_lo)
    );

    retstack_fetch #(.PROG_BYTES(PROG_BYTES)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_i   (fetch_i),
        .pc_i      (pc_w),
        .rom_data_i(rom_data_i),
        .opcode_o  (opcode_o),
        .trap_o    (trap_w)
    );

    assign pc_o   = pc_w;
    assign trap_o = trap_w;
endmodule

// File: rtl/retstack_trap_chk.sv
`timescale 1ns/1ps
module retstack_trap_chk #(
    parameter int PROG_BYTES = 4096,
    parameter int RAM_BYTES  = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        call_i,
    input logic [15:0] call_target_i,
    input logic        ret_i,
    input logic        reti_i,
    input logic        step_i,
    input logic        fetch_i,
    input logic [15:0] pc,
    input logic [7:0]  sp,
    input logic [7:0]  opcode,
    input logic        trap,
    input logic        gie
);
    localparam logic [16:0] LIMIT = 17'(PROG_BYTES);

    // R2
    call_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_i |=> (sp == $past(sp) - 8'd2) && (pc == $past(call_target_i)));

    // R3
    pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_i && (ret_i || reti_i)) |=> (sp == $past(sp) + 8'd2));

    // R4
    reti_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_i && reti_i) |=> gie);

    // R9
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !call_i && !ret_i && !reti_i) |=> (pc == $past(pc) + 16'd1) && $stable(sp));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !call_i && !ret_i && !reti_i) |=> $stable(pc) && $stable(sp));

    // R6
    undef_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && ({1'b0, pc} >= LIMIT)) |=> (opcode == 8'h00) && trap);

    // R7
    trap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> ($past(fetch_i) && (opcode == 8'h00)));

    // R10
    trap_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && !(reti_i && !call_i)) |=> !gie);
endmodule

bind retstack_trap retstack_trap_chk #(
    .PROG_BYTES(PROG_BYTES),
    .RAM_BYTES (RAM_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .call_i       (call_i),
    .call_target_i(call_target_i),
    .ret_i        (ret_i),
    .reti_i       (reti_i),
    .step_i       (step_i),
    .fetch_i      (fetch_i),
    .pc           (pc_w),
    .sp           (sp_w),
    .opcode       (opcode_o),
    .trap         (trap_w),
    .gie          (gie_o)
);

// File: tb/retstack_trap_test.sv
`timescale 1ns/1ps
module retstack_trap_test;
    localparam time CLK_P = 20ns;
    localparam int  RAMB  = 64;

    typedef struct {
        logic [15:0] pc;
        logic        gie;
        logic        trap;
        logic [7:0]  opc;
        int          req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 1'b0;
    logic [15:0] call_target_i = '0;
    logic        ret_i = 1'b0;
    logic        reti_i = 1'b0;
    logic        step_i = 1'b0;
    logic        fetch_i = 1'b0;
    logic [7:0]  rom_data;
    logic [15:0] pc_o;
    logic [7:0]  opcode_o;
    logic        trap_o;
    logic        gie_o;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];

    logic [15:0] m_pc;
    logic [7:0]  m_sp;
    logic        m_gie;
    logic [7:0]  m_opc;
    logic        prev_trap;
    logic [7:0]  m_ram [RAMB];

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] rom_byte(input logic [15:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    assign rom_data = rom_byte(pc_o);

    retstack_trap uut (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_target_i(call_target_i),
        .ret_i(ret_i), .reti_i(reti_i), .step_i(step_i), .fetch_i(fetch_i),
        .rom_data_i(rom_data), .pc_o(pc_o), .opcode_o(opcode_o),
        .trap_o(trap_o), .gie_o(gie_o)
    );

    function automatic logic [7:0] m_rd(input logic [7:0] a);
        return (int'(a) < RAMB) ? m_ram[a[5:0]] : 8'hFF;
    endfunction

    task automatic m_wr(input logic [7:0] a, input logic [7:0] d);
        if (int'(a) < RAMB) m_ram[a[5:0]] = d;
    endtask

    // driver: one cycle of stimulus, expected result pushed to the scoreboard
    task automatic cyc(input logic c, input logic [15:0] tgt, input logic r,
                       input logic ri, input logic s, input logic f, input int req);
        exp_t        e;
        logic        t;
        logic [15:0] ra;
        @(negedge clk);
        call_i = c; call_target_i = tgt; ret_i = r; reti_i = ri; step_i = s; fetch_i = f;
        t = 1'b0;
        if (f) begin
            m_opc = (m_pc >= 16'h1000) ? 8'h00 : rom_byte(m_pc);
            t = (m_opc == 8'h00);
        end
        if (prev_trap) m_gie = 1'b0;
        if (c) begin
            ra = m_pc + 16'd1;
            m_wr(m_sp, ra[7:0]);
            m_wr(m_sp - 8'd1, ra[15:8]);
            m_sp = m_sp - 8'd2;
            m_pc = tgt;
        end else if (r || ri) begin
            m_pc = {m_rd(m_sp + 8'd1), m_rd(m_sp + 8'd2)};
            m_sp = m_sp + 8'd2;
            if (ri) m_gie = 1'b1;
        end else if (s) begin
            m_pc = m_pc + 16'd1;
        end
        e.pc = m_pc; e.gie = m_gie; e.trap = t; e.opc = m_opc; e.req = req;
        q.push_back(e);
        prev_trap = t;
    endtask

    task automatic idle(input int req);
        cyc(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, req);
    endtask

    // monitor: compare outputs after each edge against the queue head
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (pc_o !== e.pc || gie_o !== e.gie || trap_o !== e.trap || opcode_o !== e.opc) begin
                    fails++;
                    $display("FAIL R%0d: pc=%h gie=%b trap=%b opc=%h expected pc=%h gie=%b trap=%b opc=%h",
                             e.req, pc_o, gie_o, trap_o, opcode_o, e.pc, e.gie, e.trap, e.opc);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        call_i = 0; ret_i = 0; reti_i = 0; step_i = 0; fetch_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pc = '0; m_sp = 8'(RAMB - 1); m_gie = 1'b0; m_opc = 8'h00; prev_trap = 1'b0;
        for (int i = 0; i < RAMB; i++) m_ram[i] = 8'h00;
        // R1: reset state visible at the ports
        checks++;
        if (pc_o !== 16'h0 || gie_o !== 1'b0 || trap_o !== 1'b0 || opcode_o !== 8'h00) begin
            fails++;
            $display("FAIL R1: pc=%h gie=%b trap=%b opc=%h expected pc=0000 gie=0 trap=0 opc=00",
                     pc_o, gie_o, trap_o, opcode_o);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R8: unbalanced return from reset reaches FFFF, next fetch traps
        cyc(0, 16'h0, 1, 0, 0, 0, 8);
        cyc(0, 16'h0, 0, 0, 0, 1, 8);
        idle(7);
        do_reset();
        // R6: fetch inside implemented memory
        cyc(0, 16'h0, 0, 0, 0, 1, 6);
        // R9: steps
        for (int i = 0; i < 3; i++) cyc(0, 16'h0, 0, 0, 1, 0, 9);
        // R2: nested calls
        cyc(1, 16'h0100, 0, 0, 0, 0, 2);
        cyc(1, 16'h0A00, 0, 0, 0, 0, 2);
        cyc(0, 16'h0, 0, 0, 1, 0, 9);
        cyc(1, 16'h0234, 0, 0, 0, 0, 2);
        // R3: LIFO returns
        cyc(0, 16'h0, 1, 0, 0, 0, 3);
        cyc(0, 16'h0, 1, 0, 0, 0, 3);
        // R4: return-from-interrupt sets enable
        cyc(0, 16'h0, 0, 1, 0, 0, 4);
        // R9: call beats return, return beats step
        cyc(1, 16'h0300, 1, 0, 0, 0, 9);
        cyc(0, 16'h0, 1, 0, 1, 0, 9);
        // R7: 00 from implemented memory traps; R10: enable cleared after it
        cyc(1, 16'h005A, 0, 0, 0, 0, 2);
        cyc(0, 16'h0, 0, 0, 0, 1, 7);
        idle(10);
        cyc(0, 16'h0, 1, 0, 0, 0, 3);
        cyc(1, 16'h0700, 0, 0, 0, 0, 2);
        cyc(0, 16'h0, 0, 1, 0, 0, 4);
        // R6: last implemented byte, then first undefined byte
        cyc(1, 16'h0FFF, 0, 0, 0, 0, 2);
        cyc(0, 16'h0, 0, 0, 0, 1, 6);
        cyc(0, 16'h0, 0, 0, 1, 0, 9);
        cyc(0, 16'h0, 0, 0, 0, 1, 6);
        // R10: return-from-interrupt while trap is high keeps enable set
        cyc(0, 16'h0, 0, 1, 0, 0, 10);
        idle(1);
        // R3 / R5: fill the stack, overflow into undefined RAM, unwind
        for (int i = 0; i < 32; i++) cyc(1, 16'h0200 + 16'(i * 8), 0, 0, 0, 0, 2);
        cyc(1, 16'h0F00, 0, 0, 0, 0, 5);
        cyc(0, 16'h0, 1, 0, 0, 0, 5);
        for (int i = 0; i < 32; i++) cyc(0, 16'h0, 1, 0, 0, 0, 3);
        idle(1);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule